// File: doc/BRIEF.md
# Split-Phase Clock Divider

The block divides its input clock by a ratio held in one 32-bit configuration word. Instead of a single terminal count, the word carries two separate counts: one sets how many input cycles the output stays high, the other how many it stays low. It also carries a pass-through flag that forwards the input clock unchanged, and a hold flag that makes a write have no effect. An odd-ratio marker bit is kept in the word for the software encoder. The output timing ignores it.

A write is offered with a one-cycle apply strobe. The accepted word waits in a pending register. It reaches the running divider only at the end of the current output period. In pass-through mode every input cycle counts as a period end. The output therefore never shows a shortened high or low phase. A readback port always reports the ratio that is currently running.

The control is a three-state machine. The states are PASS (input clock forwarded), HIGH (output high, counting the high phase) and LOW (output low, counting the low phase). The transitions are:
- PASS→PASS: the idle case, or a pending word with pass-through set.
- PASS→HIGH: a pending word with pass-through clear.
- HIGH→HIGH: the high count is not yet reached.
- HIGH→LOW: the high count is reached.
- LOW→LOW: the low count is not yet reached.
- LOW→HIGH: the period ends with no pending word, or with a pending divided word.
- LOW→PASS: the period ends with a pending pass-through word.

Top module: `clkdiv_hl`

## Requirements
- R1: The word holds the low count in bits 5:0 and the high count in bits 11:6. With pass-through (bit 13) clear, `ratio` reads high count + low count, up to 126.
- R2: With pass-through (bit 13) set, `ratio` reads 1 and `clk_div` follows `clk_in`, whatever the count fields hold.
- R3: In divided mode `clk_div` stays high for exactly the high count of input cycles, then low for the low count, and this pattern repeats.
- R4: A count field of zero, with pass-through clear, acts as a count of 1 both for timing and for `ratio`.
- R5: A new word takes effect only at the end of the current output period. The running period completes with its old high and low lengths, and `ratio` keeps the old value until then.
- R6: An apply with the hold flag (bit 14) set is ignored. Output timing and `ratio` stay as they were.
- R7: After reset the block is in pass-through. `ratio` reads 1 and `clk_div` follows `clk_in`.
- R8: Bits 31:15 of the word have no effect.
- R9: The odd-ratio marker (bit 12) has no effect on timing. A ratio N encoded as low = ceil(N/2), high = floor(N/2) gives N input cycles per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to divide |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word |
| cfg_apply | input | 1 | One-cycle strobe that offers `cfg_word` |
| clk_div | output | 1 | Divided (or passed-through) clock |
| ratio | output | 7 | Decoded ratio currently running |

## Verification
Each kind of internal fault shows up at the ports in a different way and at a different time.
- A wrong phase counter or state shows as a high or low run of the wrong length. This is visible within one output period, at most 126 input cycles.
- A word loaded at the wrong moment shows in two ways. The run in progress is cut short or stretched, and `ratio` changes one cycle after the strobe instead of at the period end.
- A mis-decoded field, such as a zero count, the hold flag or the reserved bits, shows up on `ratio` once the next period boundary has passed.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 6;
    localparam int RAT_W     = CNT_W + 1;
    localparam int LO_LSB    = 0;
    localparam int HI_LSB    = CNT_W;
    localparam int PASS_BIT  = 2 * CNT_W + 1;
    localparam int HOLD_BIT  = 2 * CNT_W + 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic pass;
        cnt_t hi;
        cnt_t lo;
    } phase_cfg_t;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_st_e;

    // Decode a word into effective counts; zero counts become 1.
    function automatic phase_cfg_t decode_word(input logic [WORD_W-1:0] w);
        phase_cfg_t c;
        c.pass = w[PASS_BIT];
        c.hi   = w[HI_LSB +: CNT_W];
        c.lo   = w[LO_LSB +: CNT_W];
        if (c.hi == '0) c.hi = cnt_t'(1);
        if (c.lo == '0) c.lo = cnt_t'(1);
        return c;
    endfunction

    function automatic logic [RAT_W-1:0] cfg_ratio(input phase_cfg_t c);
        if (c.pass) return RAT_W'(1);
        return {1'b0, c.hi} + {1'b0, c.lo};
    endfunction
endpackage

// File: rtl/clkdiv_cfg_stage.sv
module clkdiv_cfg_stage
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              apply,
    input  logic              take,
    output phase_cfg_t        pend,
    output logic              pend_v
);
    logic accept;
    assign accept = apply && !word[HOLD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= '{pass: 1'b1, hi: cnt_t'(1), lo: cnt_t'(1)};
            pend_v <= 1'b0;
        end else if (accept) begin
            pend   <= decode_word(word);
            pend_v <= 1'b1;
        end else if (take) begin
            pend_v <= 1'b0;
        end
    end

    AST_HOLD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && word[HOLD_BIT] && !take) |=> ($stable(pend) && $stable(pend_v))); // R6
endmodule

// File: rtl/clkdiv_phase_fsm.sv
module clkdiv_phase_fsm
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_cfg_t pend,
    input  logic       pend_v,
    output logic       take,
    output phase_cfg_t act,
    output logic       div_q,
    output logic       pass_q
);
    phase_st_e  st, st_nx;
    cnt_t       cnt, cnt_nx;
    phase_cfg_t act_nx;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        act_nx = act;
        take   = 1'b0;
        unique case (st)
            ST_PASS: begin
                if (pend_v) begin
                    take   = 1'b1;
                    act_nx = pend;
                    st_nx  = pend.pass ? ST_PASS : ST_HIGH;
                    cnt_nx = '0;
                end
            end
            ST_HIGH: begin
                if (cnt == cnt_t'(act.hi - 1'b1)) begin
                    st_nx  = ST_LOW;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt == cnt_t'(act.lo - 1'b1)) begin
                    cnt_nx = '0;
                    if (pend_v) begin
                        take   = 1'b1;
                        act_nx = pend;
                        st_nx  = pend.pass ? ST_PASS : ST_HIGH;
                    end else begin
                        st_nx  = ST_HIGH;
                    end
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                st_nx  = ST_PASS;
                cnt_nx = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_PASS;
            cnt <= '0;
            act <= '{pass: 1'b1, hi: cnt_t'(1), lo: cnt_t'(1)};
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            act <= act_nx;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= 1'b0;
            pass_q <= 1'b1;
        end else begin
            div_q  <= (st_nx == ST_HIGH);
            pass_q <= (st_nx == ST_PASS);
        end
    end

    AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIGH) |=> $stable(act)); // R5
    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIGH) |-> (cnt < act.hi)); // R3
    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOW) |-> (cnt < act.lo)); // R3
    AST_OUT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        div_q == (st == ST_HIGH)); // R3
endmodule

// File: rtl/clkdiv_out_mux.sv
module clkdiv_out_mux (
    input  logic clk_in,
    input  logic pass,
    input  logic div,
    output logic clk_out
);
    assign clk_out = pass ? clk_in : div;
endmodule

// File: rtl/clkdiv_hl.sv
module clkdiv_hl
    import clkdiv_pkg::*;
(
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              cfg_apply,
    output logic              clk_div,
    output logic [RAT_W-1:0]  ratio
);
    phase_cfg_t pend, act;
    logic       pend_v, take, div_q, pass_q;

    clkdiv_cfg_stage u_cfg (
        .clk(clk_in), .rst_n(rst_n), .word(cfg_word), .apply(cfg_apply),
        .take(take), .pend(pend), .pend_v(pend_v)
    );

    clkdiv_phase_fsm u_fsm (
        .clk(clk_in), .rst_n(rst_n), .pend(pend), .pend_v(pend_v),
        .take(take), .act(act), .div_q(div_q), .pass_q(pass_q)
    );

    clkdiv_out_mux u_mux (
        .clk_in(clk_in), .pass(pass_q), .div(div_q), .clk_out(clk_div)
    );

    assign ratio = cfg_ratio(act);

    AST_RATIO_NONZERO: assert property (@(posedge clk_in) disable iff (!rst_n)
        ratio != '0); // R4
    AST_PASS_RATIO: assert property (@(posedge clk_in) disable iff (!rst_n)
        pass_q |-> (ratio == RAT_W'(1))); // R2
endmodule

// File: tb/clkdiv_hl_bench.sv
module clkdiv_hl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        cfg_apply = 1'b0;
    logic        clk_div;
    logic [6:0]  ratio;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    int cur_period = 1;

    clkdiv_hl u_clkdiv_hl (
        .clk_in(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_apply(cfg_apply),
        .clk_div(clk_div), .ratio(ratio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic int w_hi(input logic [31:0] w);
        return eff(int'(w[11:6]));
    endfunction
    function automatic int w_lo(input logic [31:0] w);
        return eff(int'(w[5:0]));
    endfunction
    function automatic int w_ratio(input logic [31:0] w);
        return w[13] ? 1 : w_hi(w) + w_lo(w);
    endfunction
    function automatic logic [31:0] mk(input int hi, input int lo, input bit edg,
                                        input bit pass, input bit hold);
        logic [31:0] w = '0;
        w[5:0] = 6'(lo); w[11:6] = 6'(hi);
        w[12] = edg; w[13] = pass; w[14] = hold;
        return w;
    endfunction
    function automatic logic [31:0] enc_n(input int n);
        return mk(n / 2, (n + 1) / 2, bit'(n % 2), n == 1, 1'b0);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic samp(output logic v);
        @(negedge clk); #1; v = clk_div;
    endtask

    task automatic apply_word(input logic [31:0] w);
        @(negedge clk); #1;
        cfg_word = w; cfg_apply = 1'b1;
        @(negedge clk); #1;
        cfg_apply = 1'b0;
    endtask

    task automatic settle();
        repeat (cur_period + 3) @(negedge clk);
        #1;
    endtask

    task automatic wait_rise();
        logic p, c;
        int guard = 0;
        samp(p);
        samp(c);
        while (!(p == 1'b0 && c == 1'b1) && guard < 400) begin
            p = c; samp(c); guard++;
        end
    endtask

    task automatic measure(input int eh, input int el, input int nper, input string tag);
        logic v;
        for (int k = 0; k < nper; k++) begin
            int h = 1, l = 0;
            if (k == 0) wait_rise();
            samp(v);
            while (v == 1'b1 && h < 300) begin h++; samp(v); end
            while (v == 1'b0 && l < 300) begin l++; samp(v); end
            check(h == eh, {tag, " high run"}, h, eh);
            check(l == el, {tag, " low run"}, l, el);
        end
    endtask

    task automatic check_pass(input string tag);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            check(clk_div == 1'b1, {tag, " follow high"}, int'(clk_div), 1);
            @(negedge clk); #1;
            check(clk_div == 1'b0, {tag, " follow low"}, int'(clk_div), 0);
        end
    endtask

    task automatic go(input logic [31:0] w, input string tag);
        apply_word(w);
        settle();
        check(int'(ratio) == w_ratio(w), {tag, " ratio"}, int'(ratio), w_ratio(w));
        if (w[13]) check_pass(tag);
        else measure(w_hi(w), w_lo(w), 2, tag);
        cur_period = w_ratio(w);
    endtask

    initial begin
        logic v;
        logic [31:0] w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(ratio == 7'd1, "R7 reset ratio", int'(ratio), 1);
        check_pass("R7 reset");

        go(enc_n(3), "R9 odd N=3");
        go(enc_n(3) ^ 32'h1000, "R9 marker flipped");
        go(enc_n(8), "R1 even N=8");
        go(mk(0, 4, 0, 0, 0), "R4 zero high");
        go(mk(5, 0, 0, 0, 0), "R4 zero low");
        go(mk(63, 63, 0, 0, 0), "R1 max ratio");

        // R6: hold flag set; running pattern must be unchanged
        apply_word(mk(2, 7, 0, 0, 1));
        settle();
        check(ratio == 7'd126, "R6 hold ratio", int'(ratio), 126);
        measure(63, 63, 1, "R6 hold timing");

        go(mk(4, 3, 0, 0, 0) | 32'hFFFF_8000, "R8 reserved set");

        // R5: apply during first high cycle of a 3/2 period
        go(mk(3, 2, 0, 0, 0), "R5 setup");
        wait_rise();
        cfg_word = mk(5, 4, 0, 0, 0); cfg_apply = 1'b1;
        samp(v);
        cfg_apply = 1'b0;
        check(ratio == 7'd5, "R5 ratio before end", int'(ratio), 5);
        begin
            int h = 2, l = 0;
            samp(v);
            while (v == 1'b1 && h < 300) begin h++; samp(v); end
            while (v == 1'b0 && l < 300) begin l++; samp(v); end
            check(h == 3, "R5 old high kept", h, 3);
            check(l == 2, "R5 old low kept", l, 2);
        end
        check(ratio == 7'd9, "R5 ratio after end", int'(ratio), 9);
        measure(5, 4, 1, "R5 new period");
        cur_period = 9;

        go(mk(9, 9, 0, 1, 0), "R2 pass-through");
        go(mk(2, 2, 0, 0, 0), "R3 leave pass");

        for (int i = 0; i < 20; i++) begin
            w = $urandom;
            w[11:6] = 6'($urandom_range(0, 15));
            w[5:0]  = 6'($urandom_range(0, 15));
            w[13]   = ($urandom_range(0, 7) == 0);
            w[14]   = 1'b0;
            go(w, "R3 random");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule